// File: doc/BRIEF.md
# Per-Voice Sample Fetch Sequencer

This block walks a table of wavetable voices and, for each voice that is running, fetches a short run of 16-bit samples from system memory and resamples it to a new pitch. A control processor fills in the table through a single write port. For each voice it sets a starting sample address, a loop region, a 16.16 fixed-point phase step and a loop mode. It then starts or kills the voice with command codes on the same port.

A round-robin picker selects the next running voice. The sequencer then issues one block read request at the voice's current integer sample address and collects the returned beats into an input buffer. Only once the buffer is full does the interpolating resampler step through it. The resampler writes one output sample per cycle into a per-voice slot area of processor-local memory. When it runs out of buffered neighbours or reaches its per-turn output limit, it writes the advanced phase back to the table. That write-back releases the buffer for the next voice.

The phase wraps back into the loop region for looping voices. A one-shot voice retires itself when its integer address reaches the end address.

Top module: `sfs_fetch_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `rd_req` and `out_we` are low.
- R2: A write with `cfg_sel` = 0 sets the voice's phase to {`cfg_wdata[15:0]`, 16'h0000}. Codes 1, 2, 3 and 4 set the loop start (`cfg_wdata[15:0]`), the end address (`cfg_wdata[15:0]`), the step (`cfg_wdata[31:0]`) and the loop enable (`cfg_wdata[0]`). Code 5 starts the voice and code 6 kills it. Every read request carries `rd_voice` and, on `rd_addr`, that voice's current integer phase (phase bits 31:16).
- R3: Running voices are granted turns in ascending index order starting after the last voice served, wrapping from NV-1 to 0.
- R4: Only one request is outstanding at a time. Once raised, `rd_req` stays high with stable `rd_addr` and `rd_voice` until a cycle with `rd_gnt` high. No new request is raised while the BLK data beats of a granted block are still being delivered.
- R5: The granted block consists of BLK consecutive samples (beats on `rd_dvalid` and `rd_data`, lowest address first). No output is written before all BLK beats have arrived, and no output is written while `rd_req` is high.
- R6: Each output equals s0 + floor((s1 - s0) * f / 256). Here s0 and s1 are the signed samples at the integer phase and the one after it, and f is phase bits 15:8.
- R7: After each output the phase advances by the 32-bit step, with 16 integer and 16 fractional bits.
- R8: For a looping voice, when the advanced integer phase is greater than or equal to the end address, it becomes loop start + (integer phase - end address), and the fraction is kept.
- R9: For a non-looping voice, the output at which the advanced integer phase reaches the end address (or the phase overflows) is the last one, and the voice is never requested again.
- R10: After a kill, the voice receives no further read requests once any block already in flight has drained.
- R11: A turn writes at most OUT_MAX outputs. Output `out_addr` = {voice, slot}, where the slot counts 0, 1, 2… within the turn.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Parameter or command write strobe |
| cfg_voice | input | VW | Voice addressed by the write |
| cfg_sel | input | 3 | Field or command code (see R2) |
| cfg_wdata | input | 32 | Write data |
| rd_req | output | 1 | Block read request |
| rd_addr | output | 16 | First sample address of the block |
| rd_voice | output | VW | Voice that owns the request |
| rd_gnt | input | 1 | Request accepted |
| rd_dvalid | input | 1 | Returned sample beat valid |
| rd_data | input | 16 | Returned sample |
| out_we | output | 1 | Local memory write strobe |
| out_addr | output | VW+OW | {voice, slot} local memory address |
| out_data | output | 16 | Resampled output sample |

## Verification
The hardest situation to reach is a kill that lands while the victim voice is mid-turn. Its block is in flight and its phase write-back is still pending, so the write-back must not revive it. The stimulus keeps three looping voices cycling with short loop regions, so one of them is always in some stage of service. It kills the middle voice at an arbitrary moment and then checks that later grants alternate between the two survivors only. A loop region that starts at the very first sample and a step of 10.0 force wraps and one-output blocks, which a gentle step would never produce.

// File: rtl/sfs_pkg.sv
package sfs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_FILL,
        ST_PROC,
        ST_WB
    } sfs_state_e;

    localparam logic [2:0] SEL_PHASE = 3'd0;
    localparam logic [2:0] SEL_LSTART = 3'd1;
    localparam logic [2:0] SEL_LEND = 3'd2;
    localparam logic [2:0] SEL_STEP = 3'd3;
    localparam logic [2:0] SEL_MODE = 3'd4;
    localparam logic [2:0] SEL_RUN = 3'd5;
    localparam logic [2:0] SEL_KILL = 3'd6;

    typedef struct packed {
        logic [31:0] phase;
        logic [15:0] lstart;
        logic [15:0] lend;
        logic [31:0] step;
        logic        loop_en;
        logic        active;
    } voice_t;

endpackage

// File: rtl/sfs_voice_regs.sv
module sfs_voice_regs
    import sfs_pkg::*;
#(
    parameter int NV = 64,
    parameter int VW = $clog2(NV)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_we,
    input  logic [VW-1:0] cfg_voice,
    input  logic [2:0]    cfg_sel,
    input  logic [31:0]   cfg_wdata,
    input  logic          wb_en,
    input  logic [VW-1:0] wb_voice,
    input  logic [31:0]   wb_phase,
    input  logic          wb_end,
    input  logic [VW-1:0] rd_sel,
    output voice_t        rd_entry,
    output logic [NV-1:0] act_vec
);

    voice_t tbl_d [NV];
    voice_t tbl_q [NV];

    always_comb begin
        for (int i = 0; i < NV; i++) begin
            tbl_d[i] = tbl_q[i];
        end
        // write-back of the serviced voice first, processor writes win
        if (wb_en) begin
            tbl_d[wb_voice].phase = wb_phase;
            if (wb_end) begin
                tbl_d[wb_voice].active = 1'b0;
            end
        end
        if (cfg_we) begin
            case (cfg_sel)
                SEL_PHASE:  tbl_d[cfg_voice].phase = {cfg_wdata[15:0], 16'h0000};
                SEL_LSTART: tbl_d[cfg_voice].lstart = cfg_wdata[15:0];
                SEL_LEND:   tbl_d[cfg_voice].lend = cfg_wdata[15:0];
                SEL_STEP:   tbl_d[cfg_voice].step = cfg_wdata;
                SEL_MODE:   tbl_d[cfg_voice].loop_en = cfg_wdata[0];
                SEL_RUN:    tbl_d[cfg_voice].active = 1'b1;
                SEL_KILL:   tbl_d[cfg_voice].active = 1'b0;
                default:    ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < NV; i++) begin
                tbl_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < NV; i++) begin
                tbl_q[i] <= tbl_d[i];
            end
        end
    end

    assign rd_entry = tbl_q[rd_sel];

    for (genvar g = 0; g < NV; g++) begin : g_act
        assign act_vec[g] = tbl_q[g].active;
    end

endmodule

// File: rtl/sfs_rr_pick.sv
module sfs_rr_pick #(
    parameter int NV = 64,
    parameter int VW = $clog2(NV)
) (
    input  logic [NV-1:0] act_vec,
    input  logic [VW-1:0] last,
    output logic          found,
    output logic [VW-1:0] pick
);

    always_comb begin
        int idx;
        found = 1'b0;
        pick = last;
        for (int i = 1; i <= NV; i++) begin
            idx = (int'(last) + i) % NV;
            if (!found && act_vec[idx]) begin
                found = 1'b1;
                pick = VW'(idx);
            end
        end
    end

endmodule

// File: rtl/sfs_interp.sv
module sfs_interp (
    input  logic [15:0] s0,
    input  logic [15:0] s1,
    input  logic [7:0]  frac,
    output logic [15:0] y
);

    logic signed [16:0] diff;
    logic signed [8:0]  wgt;
    logic signed [25:0] prod;
    logic signed [25:0] sum;

    always_comb begin
        diff = $signed({s1[15], s1}) - $signed({s0[15], s0});
        wgt = $signed({1'b0, frac});
        prod = diff * wgt;
        sum = $signed({{10{s0[15]}}, s0}) + (prod >>> 8);
        y = sum[15:0];
    end

endmodule

// File: rtl/sfs_fetch_seq.sv
module sfs_fetch_seq
    import sfs_pkg::*;
#(
    parameter int NV = 64,
    parameter int BLK = 8,
    parameter int OUT_MAX = 8,
    localparam int VW = $clog2(NV),
    localparam int BW = $clog2(BLK),
    localparam int OW = $clog2(OUT_MAX),
    localparam int CW = $clog2((BLK > OUT_MAX) ? BLK : OUT_MAX) + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [VW-1:0]    cfg_voice,
    input  logic [2:0]       cfg_sel,
    input  logic [31:0]      cfg_wdata,
    output logic             rd_req,
    output logic [15:0]      rd_addr,
    output logic [VW-1:0]    rd_voice,
    input  logic             rd_gnt,
    input  logic             rd_dvalid,
    input  logic [15:0]      rd_data,
    output logic             out_we,
    output logic [VW+OW-1:0] out_addr,
    output logic [15:0]      out_data
);

    typedef struct packed {
        sfs_state_e    st;
        logic [VW-1:0] cur;
        logic [VW-1:0] last;
        logic [31:0]   phase;
        logic [15:0]   lstart;
        logic [15:0]   lend;
        logic [31:0]   step;
        logic          loop_en;
        logic [15:0]   base;
        logic [CW-1:0] cnt;
        logic          ended;
    } ctl_t;

    ctl_t        c_d, c_q;
    logic [15:0] buf_d [BLK];
    logic [15:0] buf_q [BLK];

    voice_t        sel_entry;
    logic [NV-1:0] act_vec;
    logic          pick_found;
    logic [VW-1:0] pick_voice;
    logic          wb_en;
    logic [15:0]   rel;
    logic [15:0]   rel1;
    logic          can_out;
    logic [32:0]   adv;
    logic [15:0]   adv_int;
    logic          adv_past;
    logic [15:0]   interp_y;

    sfs_voice_regs #(.NV(NV), .VW(VW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_we   (cfg_we),
        .cfg_voice(cfg_voice),
        .cfg_sel  (cfg_sel),
        .cfg_wdata(cfg_wdata),
        .wb_en    (wb_en),
        .wb_voice (c_q.cur),
        .wb_phase (c_q.phase),
        .wb_end   (c_q.ended),
        .rd_sel   (pick_voice),
        .rd_entry (sel_entry),
        .act_vec  (act_vec)
    );

    sfs_rr_pick #(.NV(NV), .VW(VW)) u_pick (
        .act_vec(act_vec),
        .last   (c_q.last),
        .found  (pick_found),
        .pick   (pick_voice)
    );

    sfs_interp u_interp (
        .s0  (buf_q[rel[BW-1:0]]),
        .s1  (buf_q[rel1[BW-1:0]]),
        .frac(c_q.phase[15:8]),
        .y   (interp_y)
    );

    always_comb begin
        rel = c_q.phase[31:16] - c_q.base;
        rel1 = rel + 16'd1;
        can_out = (rel < 16'(BLK - 1)) && (c_q.cnt < CW'(OUT_MAX));
        adv = {1'b0, c_q.phase} + {1'b0, c_q.step};
        adv_int = adv[31:16];
        adv_past = adv[32] || (adv_int >= c_q.lend);
    end

    always_comb begin
        c_d = c_q;
        for (int i = 0; i < BLK; i++) begin
            buf_d[i] = buf_q[i];
        end
        wb_en = 1'b0;
        out_we = 1'b0;
        case (c_q.st)
            ST_IDLE: begin
                if (pick_found) begin
                    c_d.cur = pick_voice;
                    c_d.phase = sel_entry.phase;
                    c_d.lstart = sel_entry.lstart;
                    c_d.lend = sel_entry.lend;
                    c_d.step = sel_entry.step;
                    c_d.loop_en = sel_entry.loop_en;
                    c_d.ended = 1'b0;
                    c_d.st = ST_REQ;
                end
            end
            ST_REQ: begin
                if (rd_gnt) begin
                    c_d.base = c_q.phase[31:16];
                    c_d.cnt = '0;
                    c_d.st = ST_FILL;
                end
            end
            ST_FILL: begin
                if (rd_dvalid) begin
                    buf_d[c_q.cnt[BW-1:0]] = rd_data;
                    c_d.cnt = c_q.cnt + 1'b1;
                    if (c_q.cnt == CW'(BLK - 1)) begin
                        c_d.cnt = '0;
                        c_d.st = ST_PROC;
                    end
                end
            end
            ST_PROC: begin
                if (can_out) begin
                    out_we = 1'b1;
                    c_d.cnt = c_q.cnt + 1'b1;
                    if (adv_past) begin
                        if (c_q.loop_en) begin
                            c_d.phase = {c_q.lstart + (adv_int - c_q.lend), adv[15:0]};
                        end else begin
                            c_d.phase = adv[31:0];
                            c_d.ended = 1'b1;
                            c_d.st = ST_WB;
                        end
                    end else begin
                        c_d.phase = adv[31:0];
                    end
                end else begin
                    c_d.st = ST_WB;
                end
            end
            ST_WB: begin
                wb_en = 1'b1;
                c_d.last = c_q.cur;
                c_d.st = ST_IDLE;
            end
            default: c_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q <= '{st: ST_IDLE, last: VW'(NV - 1), default: '0};
            for (int i = 0; i < BLK; i++) begin
                buf_q[i] <= '0;
            end
        end else begin
            c_q <= c_d;
            for (int i = 0; i < BLK; i++) begin
                buf_q[i] <= buf_d[i];
            end
        end
    end

    assign rd_req = (c_q.st == ST_REQ);
    assign rd_addr = c_q.phase[31:16];
    assign rd_voice = c_q.cur;
    assign out_addr = {c_q.cur, c_q.cnt[OW-1:0]};
    assign out_data = interp_y;

endmodule

// File: rtl/sfs_fetch_seq_chk.sv
module sfs_fetch_seq_chk #(
    parameter int VW = 6,
    parameter int OAW = 9
) (
    input logic           clk,
    input logic           rst_n,
    input logic           rd_req,
    input logic           rd_gnt,
    input logic [15:0]    rd_addr,
    input logic [VW-1:0]  rd_voice,
    input logic           out_we,
    input logic [OAW-1:0] out_addr
);

    // R1
    quiet_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!rd_req && !out_we));

    // R4
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !rd_gnt) |=> (rd_req && $stable(rd_addr) && $stable(rd_voice)));

    // R5
    no_out_while_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req |-> !out_we);

    // R11
    slot_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_we && $past(out_we)) |-> (out_addr == $past(out_addr) + 1'b1));

endmodule

bind sfs_fetch_seq sfs_fetch_seq_chk #(.VW(VW), .OAW(VW + OW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .rd_req  (rd_req),
    .rd_gnt  (rd_gnt),
    .rd_addr (rd_addr),
    .rd_voice(rd_voice),
    .out_we  (out_we),
    .out_addr(out_addr)
);

// File: tb/sfs_fetch_seq_test.sv
module sfs_fetch_seq_test;

    localparam int NV = 64;
    localparam int BLK = 8;
    localparam int OUT_MAX = 8;
    localparam int VW = 6;
    localparam int OW = 3;
    localparam int WATCHDOG = 150000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [VW-1:0]    cfg_voice = '0;
    logic [2:0]       cfg_sel = '0;
    logic [31:0]      cfg_wdata = '0;
    logic             rd_req;
    logic [15:0]      rd_addr;
    logic [VW-1:0]    rd_voice;
    logic             rd_gnt = 1'b0;
    logic             rd_dvalid = 1'b0;
    logic [15:0]      rd_data = '0;
    logic             out_we;
    logic [VW+OW-1:0] out_addr;
    logic [15:0]      out_data;

    sfs_fetch_seq #(.NV(NV), .BLK(BLK), .OUT_MAX(OUT_MAX)) uut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_voice(cfg_voice),
        .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata), .rd_req(rd_req),
        .rd_addr(rd_addr), .rd_voice(rd_voice), .rd_gnt(rd_gnt),
        .rd_dvalid(rd_dvalid), .rd_data(rd_data), .out_we(out_we),
        .out_addr(out_addr), .out_data(out_data)
    );

    always #5 clk = ~clk;

    // vector table: voice, start, loop start, end, step, loop, outputs to watch
    localparam int NVEC = 7;
    localparam int V_VOICE [NVEC] = '{0, 9, 33, 63, 17, 5, 6};
    localparam int V_START [NVEC] = '{100, 200, 300, 400, 500, 600, 700};
    localparam int V_LS [NVEC] = '{0, 0, 0, 404, 500, 0, 0};
    localparam int V_LE [NVEC] = '{120, 205, 340, 410, 503, 601, 800};
    localparam logic [31:0] V_STEP [NVEC] = '{32'h0001_0000, 32'h0000_4000,
        32'h0002_8000, 32'h0001_6000, 32'h0000_C000, 32'h0003_0000, 32'h000A_0000};
    localparam bit V_LOOP [NVEC] = '{0, 0, 0, 1, 1, 0, 0};
    localparam int V_WATCH [NVEC] = '{0, 0, 0, 40, 30, 0, 0};

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    bit done = 1'b0;

    logic [31:0] r_phase [NV];
    logic [15:0] r_ls [NV];
    logic [15:0] r_le [NV];
    logic [31:0] r_step [NV];
    bit          r_loop [NV];
    bit          r_ended [NV];
    bit          r_dead [NV];
    int          r_outs [NV];
    int          glog [4096];
    int          gcount = 0;
    bit          in_burst = 1'b0;
    logic        prev_we = 1'b0;
    logic [OW-1:0] prev_slot = '0;

    function automatic logic [15:0] memval(input logic [15:0] a);
        int t;
        t = int'(a) * 2749 + 12345;
        return t[15:0];
    endfunction

    function automatic logic [15:0] interp_ref(input logic [31:0] p);
        int s0, s1, f, y;
        s0 = int'($signed(memval(p[31:16])));
        s1 = int'($signed(memval(p[31:16] + 16'd1)));
        f = int'(p[15:8]);
        y = s0 + (((s1 - s0) * f) >>> 8);
        return y[15:0];
    endfunction

    function automatic int count_noloop(input logic [31:0] p0, input logic [15:0] le,
                                        input logic [31:0] st);
        logic [32:0] s;
        logic [31:0] p;
        int n;
        p = p0;
        n = 0;
        for (int k = 0; k < 100000; k++) begin
            n++;
            s = {1'b0, p} + {1'b0, st};
            if (s[32] || s[31:16] >= le) break;
            p = s[31:0];
        end
        return n;
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cfg(input int v, input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1;
        cfg_voice = VW'(v);
        cfg_sel = sel;
        cfg_wdata = d;
        case (sel)
            3'd0: r_phase[v] = {d[15:0], 16'h0000};
            3'd1: r_ls[v] = d[15:0];
            3'd2: r_le[v] = d[15:0];
            3'd3: r_step[v] = d;
            3'd4: r_loop[v] = d[0];
            3'd5: begin r_ended[v] = 1'b0; r_dead[v] = 1'b0; end
            default: ;
        endcase
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic setup_voice(input int v, input int st, input int ls, input int le,
                               input logic [31:0] step, input bit lp);
        cfg(v, 3'd0, 32'(st));
        cfg(v, 3'd1, 32'(ls));
        cfg(v, 3'd2, 32'(le));
        cfg(v, 3'd3, step);
        cfg(v, 3'd4, {31'd0, lp});
        r_outs[v] = 0;
    endtask

    task automatic wait_cycles(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // memory responder: grant, then BLK consecutive beats
    initial begin
        forever begin
            @(negedge clk);
            if (rd_req && rst_n) begin
                logic [15:0] a;
                int v;
                a = rd_addr;
                v = int'(rd_voice);
                // R2: request address is the voice's integer phase
                check(a == r_phase[v][31:16], "R2 request address", int'(a), int'(r_phase[v][31:16]));
                // R9/R10: retired or killed voices never requested
                check(!r_ended[v] && !r_dead[v], "R10/R9 request for stopped voice", v, -1);
                glog[gcount % 4096] = v;
                gcount++;
                rd_gnt = 1'b1;
                @(negedge clk);
                rd_gnt = 1'b0;
                in_burst = 1'b1;
                for (int i = 0; i < BLK; i++) begin
                    rd_dvalid = 1'b1;
                    rd_data = memval(a + 16'(i));
                    if (i < BLK - 1) @(negedge clk);
                end
                @(posedge clk);
                #1 in_burst = 1'b0;
                @(negedge clk);
                rd_dvalid = 1'b0;
            end
        end
    end

    // output monitor and reference model
    always @(negedge clk) begin
        if (rst_n) begin
            if (in_burst) begin
                // R5: no output before the block is complete
                check(!out_we, "R5 output during fill", int'(out_we), 0);
                // R4: no new request while a block is delivered
                check(!rd_req, "R4 request during fill", int'(rd_req), 0);
            end
            if (out_we) begin
                int v;
                logic [OW-1:0] slot;
                logic [32:0] s;
                logic [15:0] e;
                v = int'(out_addr[VW+OW-1:OW]);
                slot = out_addr[OW-1:0];
                // R11: slot numbering within a turn
                check(slot == (prev_we ? prev_slot + 1'b1 : '0), "R11 slot", int'(slot),
                      prev_we ? int'(prev_slot) + 1 : 0);
                check(!r_ended[v], "R9 output after end", v, -1);
                e = interp_ref(r_phase[v]);
                // R6/R7/R8: interpolated value at reference phase
                check(out_data == e, "R6 interpolation", int'(out_data), int'(e));
                s = {1'b0, r_phase[v]} + {1'b0, r_step[v]};
                if (s[32] || s[31:16] >= r_le[v]) begin
                    if (r_loop[v]) r_phase[v] = {r_ls[v] + (s[31:16] - r_le[v]), s[15:0]};
                    else begin r_phase[v] = s[31:0]; r_ended[v] = 1'b1; end
                end else begin
                    r_phase[v] = s[31:0];
                end
                r_outs[v]++;
                prev_slot = slot;
            end
            prev_we = out_we;
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > WATCHDOG && !done) begin
            done = 1'b1;
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog cycles=%0d expected below %0d", cycles, WATCHDOG);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    function automatic int succ3(input int v);
        return (v == 10) ? 20 : (v == 20) ? 30 : 10;
    endfunction

    initial begin
        for (int i = 0; i < NV; i++) begin
            r_phase[i] = '0; r_ls[i] = '0; r_le[i] = '0; r_step[i] = '0;
            r_loop[i] = 1'b0; r_ended[i] = 1'b0; r_dead[i] = 1'b0; r_outs[i] = 0;
        end
        // R1: quiet during and right after reset
        wait_cycles(3);
        check(!rd_req && !out_we, "R1 during reset", int'({rd_req, out_we}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!rd_req && !out_we, "R1 after reset", int'({rd_req, out_we}), 0);
        wait_cycles(5);
        check(!rd_req, "R1 idle with no voice", int'(rd_req), 0);

        // vector walk
        for (int k = 0; k < NVEC; k++) begin
            int v;
            int expn;
            v = V_VOICE[k];
            setup_voice(v, V_START[k], V_LS[k], V_LE[k], V_STEP[k], V_LOOP[k]);
            cfg(v, 3'd5, 32'd0);
            if (V_LOOP[k]) begin
                for (int c = 0; c < 5000 && r_outs[v] < V_WATCH[k]; c++) @(negedge clk);
                // R8: looping voice keeps producing
                check(r_outs[v] >= V_WATCH[k], "R8 loop outputs", r_outs[v], V_WATCH[k]);
                cfg(v, 3'd6, 32'd0);
                wait_cycles(60);
                r_dead[v] = 1'b1;
                wait_cycles(40);
            end else begin
                expn = count_noloop({16'(V_START[k]), 16'h0000}, 16'(V_LE[k]), V_STEP[k]);
                for (int c = 0; c < 5000 && r_outs[v] < expn; c++) @(negedge clk);
                wait_cycles(60);
                // R9: one-shot voice produces exactly the outputs up to its end
                check(r_outs[v] == expn, "R9 one-shot output count", r_outs[v], expn);
                check(r_ended[v], "R9 voice retired", int'(r_ended[v]), 1);
            end
        end

        // R3: round-robin among three looping voices
        setup_voice(10, 1000, 1000, 1004, 32'h0000_4000, 1'b1);
        setup_voice(20, 2000, 2000, 2006, 32'h0000_8000, 1'b1);
        setup_voice(30, 3000, 3001, 3005, 32'h0000_6000, 1'b1);
        cfg(30, 3'd5, 32'd0);
        cfg(10, 3'd5, 32'd0);
        cfg(20, 3'd5, 32'd0);
        begin
            int g0;
            g0 = gcount + 3;
            for (int c = 0; c < 20000 && gcount < g0 + 9; c++) @(negedge clk);
            for (int j = g0; j < g0 + 9; j++) begin
                // R3: next grant is the next running voice in index order
                check(glog[j % 4096] == succ3(glog[(j - 1) % 4096]), "R3 round-robin order",
                      glog[j % 4096], succ3(glog[(j - 1) % 4096]));
            end
        end

        // R10: kill the middle voice while all three cycle
        wait_cycles(7);
        cfg(20, 3'd6, 32'd0);
        wait_cycles(60);
        r_dead[20] = 1'b1;
        begin
            int g1;
            g1 = gcount + 1;
            for (int c = 0; c < 20000 && gcount < g1 + 8; c++) @(negedge clk);
            for (int j = g1; j < g1 + 8; j++) begin
                int p, q;
                p = glog[(j - 1) % 4096];
                q = glog[j % 4096];
                check((p == 10 && q == 30) || (p == 30 && q == 10), "R10 survivors alternate",
                      q, (p == 10) ? 30 : 10);
            end
        end
        cfg(10, 3'd6, 32'd0);
        cfg(30, 3'd6, 32'd0);
        wait_cycles(60);
        r_dead[10] = 1'b1;
        r_dead[30] = 1'b1;
        wait_cycles(50);
        check(!rd_req, "R10 all killed, idle", int'(rd_req), 0);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

endmodule